// File: doc/BRIEF.md
# End-Around Carry Magnitude Adder

This block is the final carry-propagate adder of a fused multiply-add datapath. It takes two 128-bit operand vectors and an effective-subtract control. In add mode it returns the ordinary sum and a carry-out. In subtract mode it returns the magnitude of the difference, with a flag that is set when the true difference `a - b` was negative. The result comes out in sign-magnitude form after a single pass. No second subtraction and no pass to negate the result are needed.

In subtract mode the adder forms `a + ~b`. The operand width is cut into equal groups, 32 bits each by default. Each group works out its own generate and propagate terms, and it prepares two conditional sums: one for a carry-in of 0 and one for a carry-in of 1. A carry network builds each group's carry-in from the group terms. That carry-in includes the carry that wraps from the top group back into the bottom group, so the wrap resolves without a combinational loop. If the wrap carry is 1, then `a > b` and the selected sums already equal `a - b`. If it is 0, then `b >= a` and the bitwise complement of the selected sums gives `b - a`. In add mode the wrap path is masked, so the carries are the ordinary ones with a carry-in of 0. An optional output register, on by default, holds the three results.

Top module: `eac_mag_adder`

## Requirements
- R1: With `sub`=0, `{carry_out, result}` equals the 129-bit sum `a + b`.
- R2: With `sub`=1 and `a > b` (unsigned), `result` equals `a - b` and `negative` is 0.
- R3: With `sub`=1 and `b > a`, `result` equals `b - a` and `negative` is 1.
- R4: With `sub`=1 and `a == b`, `result` is all zeros and `negative` is 0.
- R5: `carry_out` is 0 whenever `sub`=1, and `negative` is 0 whenever `sub`=0.
- R6: With OUT_REG=1 (the default), each result appears one clock after its operands were sampled. While `rst_n` is 0 at a rising edge, all outputs are cleared to 0.
- R7: Carries that cross any 32-bit group boundary are resolved correctly. This includes the end-around carry out of the top group, which ripples up through every lower group.
- R8: The corner operands all-ones and all-zero give the values from R1 to R4 in both modes. For example, all-ones plus all-ones gives `carry_out`=1 and a result of all ones except bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a | input | 128 | First operand |
| b | input | 128 | Second operand (the subtrahend in subtract mode) |
| sub | input | 1 | 1 = subtract and return the magnitude, 0 = add |
| result | output | 128 | Sum, or magnitude of the difference |
| negative | output | 1 | Set when `a - b` is negative (subtract mode only) |
| carry_out | output | 1 | Carry out of the add (add mode only) |

## Verification
The adder core is purely combinational, and the only register sits at the output, so every result is due exactly one rising edge after its operands were applied. The bench drives operands on a falling edge and reads all three outputs on the next falling edge. One rising edge lies between those two points, so the bench never samples in the same cycle as the edge. A reset check holds `rst_n` low across a rising edge and expects zeros at the following falling edge. The bound checker compares the combinational core with `a + b`, `a - b` or `b - a` in the same cycle, and compares the registered outputs with the core's value one cycle earlier.

// File: rtl/eac_pkg.sv
// Package eac_pkg
// Types shared by the end-around carry adder. Assumes nothing beyond
// the group generate/propagate pair each group reports to the carry net.
package eac_pkg;

    // Group-level carry terms: generate with carry-in 0, and all-propagate.
    typedef struct packed {
        logic gen;
        logic prop;
    } grp_gp_t;

endpackage : eac_pkg

// File: rtl/eac_group.sv
// Module eac_group
// One slice of the adder. It conditionally inverts the second operand,
// then forms two conditional sums (carry-in 0 and carry-in 1) and the
// group generate/propagate terms. Assumes GW >= 1. Purely combinational.
module eac_group
    import eac_pkg::*;
#(
    parameter int GW = 32
) (
    input  logic [GW-1:0] op_x,
    input  logic [GW-1:0] op_y,
    input  logic          inv_y,
    output logic [GW-1:0] sum_c0,
    output logic [GW-1:0] sum_c1,
    output logic          cout_c1,
    output grp_gp_t       gp
);

    logic [GW-1:0] y_eff;
    logic [GW:0]   wide_c0;
    logic [GW:0]   wide_c1;

    // Operand conditioning: take the one's complement of y when subtracting.
    always_comb begin
        y_eff = inv_y ? ~op_y : op_y;
    end

    // Conditional sums for both carry-in values, with group terms.
    always_comb begin
        wide_c0  = {1'b0, op_x} + {1'b0, y_eff};
        wide_c1  = {1'b0, op_x} + {1'b0, y_eff} + {{GW{1'b0}}, 1'b1};
        sum_c0   = wide_c0[GW-1:0];
        sum_c1   = wide_c1[GW-1:0];
        cout_c1  = wide_c1[GW];
        gp.gen   = wide_c0[GW];
        gp.prop  = &(op_x ^ y_eff);
    end

endmodule : eac_group

// File: rtl/eac_carry_net.sv
// Module eac_carry_net
// Builds the carry into each group from the group generate/propagate
// terms. The carry out of the top group wraps back into group 0 when
// wrap_en is set. The wrap is taken from the carry with carry-in 0, so
// there is no loop: when every group propagates, the wrap stays 0, which
// is the correct choice for equal operands. Assumes NG >= 2.
module eac_carry_net
    import eac_pkg::*;
#(
    parameter int NG = 4
) (
    input  grp_gp_t [NG-1:0] gp,
    input  logic             wrap_en,
    output logic [NG-1:0]    grp_cin,
    output logic             top_cout,
    output logic             all_prop
);

    logic [NG:0]   conv_c;
    logic [NG-1:0] prop_pre;
    logic          wrap_c;

    // Conventional group carries with carry-in 0, plus running propagate.
    always_comb begin
        conv_c[0]   = 1'b0;
        prop_pre[0] = 1'b1;
        for (int i = 0; i < NG; i++) begin
            conv_c[i+1] = gp[i].gen | (gp[i].prop & conv_c[i]);
        end
        for (int i = 1; i < NG; i++) begin
            prop_pre[i] = prop_pre[i-1] & gp[i-1].prop;
        end
    end

    // End-around term: top carry-out fed back only in subtract mode.
    always_comb begin
        top_cout = conv_c[NG];
        wrap_c   = wrap_en & conv_c[NG];
        all_prop = prop_pre[NG-1] & gp[NG-1].prop;
    end

    // Group carry-in: conventional carry, or wrap carry through lower groups.
    always_comb begin
        for (int i = 0; i < NG; i++) begin
            grp_cin[i] = conv_c[i] | (prop_pre[i] & wrap_c);
        end
    end

endmodule : eac_carry_net

// File: rtl/eac_select.sv
// Module eac_select
// Final sum selection. Each group carry picks one of the two conditional
// sums, and the whole word is complemented when the subtract result must
// be flipped to a magnitude. Purely combinational.
module eac_select #(
    parameter int GW = 32,
    parameter int NG = 4,
    localparam int W = GW * NG
) (
    input  logic [W-1:0]  sums_c0,
    input  logic [W-1:0]  sums_c1,
    input  logic [NG-1:0] grp_cin,
    input  logic          flip,
    output logic [W-1:0]  sum_sel
);

    for (genvar g = 0; g < NG; g++) begin : g_sel
        // Per-group multiplexer followed by conditional complement.
        always_comb begin
            sum_sel[g*GW +: GW] = (grp_cin[g] ? sums_c1[g*GW +: GW]
                                              : sums_c0[g*GW +: GW])
                                  ^ {GW{flip}};
        end
    end

endmodule : eac_select

// File: rtl/eac_mag_adder.sv
// Module eac_mag_adder
// Top of the end-around carry magnitude adder. Add mode gives a + b with
// a carry-out. Subtract mode gives |a - b| and a negative flag, all in one
// pass. Assumes WIDTH is a multiple of GROUPS. With OUT_REG=1 the outputs
// are registered, with a synchronous active-low reset; with OUT_REG=0 they
// are combinational.
module eac_mag_adder
    import eac_pkg::*;
#(
    parameter int WIDTH   = 128,
    parameter int GROUPS  = 4,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] result,
    output logic             negative,
    output logic             carry_out
);

    localparam int GW = WIDTH / GROUPS;

    logic [WIDTH-1:0]    sums_c0;
    logic [WIDTH-1:0]    sums_c1;
    logic [GROUPS-1:0]   cout_c1;
    grp_gp_t [GROUPS-1:0] gp;
    logic [GROUPS-1:0]   grp_cin;
    logic                top_cout;
    logic                all_prop;
    logic                flip;
    logic [WIDTH-1:0]    core_res;
    logic                core_neg;
    logic                core_co;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        eac_group #(.GW(GW)) i_grp (
            .op_x    (a[g*GW +: GW]),
            .op_y    (b[g*GW +: GW]),
            .inv_y   (sub),
            .sum_c0  (sums_c0[g*GW +: GW]),
            .sum_c1  (sums_c1[g*GW +: GW]),
            .cout_c1 (cout_c1[g]),
            .gp      (gp[g])
        );
    end

    eac_carry_net #(.NG(GROUPS)) i_cnet (
        .gp       (gp),
        .wrap_en  (sub),
        .grp_cin  (grp_cin),
        .top_cout (top_cout),
        .all_prop (all_prop)
    );

    // Complement when subtracting and the wrap carry is absent (b >= a).
    always_comb begin
        flip = sub & ~top_cout;
    end

    eac_select #(.GW(GW), .NG(GROUPS)) i_sel (
        .sums_c0 (sums_c0),
        .sums_c1 (sums_c1),
        .grp_cin (grp_cin),
        .flip    (flip),
        .sum_sel (core_res)
    );

    // Flags: negative only for a strict b > a; carry-out only in add mode.
    always_comb begin
        core_neg = sub & ~top_cout & ~all_prop;
        core_co  = ~sub & top_cout;
    end

    if (OUT_REG) begin : g_oreg
        // Output register with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result    <= '0;
                negative  <= 1'b0;
                carry_out <= 1'b0;
            end else begin
                result    <= core_res;
                negative  <= core_neg;
                carry_out <= core_co;
            end
        end
    end else begin : g_comb
        // Pass-through when no output stage is wanted.
        always_comb begin
            result    = core_res;
            negative  = core_neg;
            carry_out = core_co;
        end
    end

endmodule : eac_mag_adder

// File: rtl/eac_mag_adder_chk.sv
// Module eac_mag_adder_chk
// Assertion checker bound to eac_mag_adder. It compares the combinational
// core with arithmetic on the operands, checks the group carry identity,
// and checks the output register's latency.
module eac_mag_adder_chk #(
    parameter int WIDTH   = 128,
    parameter int GROUPS  = 4,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WIDTH-1:0]  a,
    input logic [WIDTH-1:0]  b,
    input logic              sub,
    input logic [WIDTH-1:0]  result,
    input logic              negative,
    input logic              carry_out,
    input logic [WIDTH-1:0]  core_res,
    input logic              core_neg,
    input logic              core_co,
    input logic [GROUPS-1:0] cout_c1,
    input logic [GROUPS-1:0] gen_v,
    input logic [GROUPS-1:0] prop_v
);

    a_r1_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        !sub |-> ({core_co, core_res} == ({1'b0, a} + {1'b0, b})));

    a_r2_sub_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (sub && a > b) |-> (core_res == a - b && !core_neg));

    a_r3_sub_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (sub && b > a) |-> (core_res == b - a && core_neg));

    a_r4_equal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sub && a == b) |-> (core_res == '0 && !core_neg));

    a_r5_flag_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (sub |-> !core_co) and (!sub |-> !core_neg));

    // R7: the carry with carry-in 1 equals the carry with carry-in 0 ORed
    // with the group propagate.
    a_r7_carry_identity: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (cout_c1 == (gen_v | prop_v)));

    if (OUT_REG) begin : g_lat
        a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (result == $past(core_res) &&
                              negative == $past(core_neg) &&
                              carry_out == $past(core_co)));
    end

endmodule : eac_mag_adder_chk

bind eac_mag_adder eac_mag_adder_chk #(
    .WIDTH   (WIDTH),
    .GROUPS  (GROUPS),
    .OUT_REG (OUT_REG)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a         (a),
    .b         (b),
    .sub       (sub),
    .result    (result),
    .negative  (negative),
    .carry_out (carry_out),
    .core_res  (core_res),
    .core_neg  (core_neg),
    .core_co   (core_co),
    .cout_c1   (cout_c1),
    .gen_v     ({gp[3].gen, gp[2].gen, gp[1].gen, gp[0].gen}),
    .prop_v    ({gp[3].prop, gp[2].prop, gp[1].prop, gp[0].prop})
);

// File: tb/test_eac_mag_adder.sv
// Directed bench for eac_mag_adder: one task for each scenario, each
// checking its own results one clock after it drives the operands.
module test_eac_mag_adder;

    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         sub = 1'b0;
    logic [W-1:0] result;
    logic         negative;
    logic         carry_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    eac_mag_adder i_eac_mag_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .a         (a),
        .b         (b),
        .sub       (sub),
        .result    (result),
        .negative  (negative),
        .carry_out (carry_out)
    );

    function automatic logic [W-1:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // Drive on a falling edge, then read on the next falling edge.
    task automatic apply_and_check(input logic [W-1:0] xa, input logic [W-1:0] xb,
                                   input logic xs, input string req);
        logic [W:0]   sum_ref;
        logic [W-1:0] res_ref;
        logic         neg_ref;
        logic         co_ref;
        @(negedge clk);
        a = xa; b = xb; sub = xs;
        if (!xs) begin
            sum_ref = {1'b0, xa} + {1'b0, xb};
            res_ref = sum_ref[W-1:0];
            co_ref  = sum_ref[W];
            neg_ref = 1'b0;
        end else begin
            co_ref  = 1'b0;
            neg_ref = (xb > xa);
            res_ref = (xa >= xb) ? xa - xb : xb - xa;
        end
        @(negedge clk);
        total++;
        if (result !== res_ref || negative !== neg_ref || carry_out !== co_ref) begin
            bad++;
            $display("FAIL %s: result=%h neg=%b co=%b expected result=%h neg=%b co=%b",
                     req, result, negative, carry_out, res_ref, neg_ref, co_ref);
        end
    endtask

    // R6: outputs are cleared while reset is held across an edge.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; a = '1; b = '1; sub = 1'b0;
        @(negedge clk);
        total++;
        if (result !== '0 || negative !== 1'b0 || carry_out !== 1'b0) begin
            bad++;
            $display("FAIL R6 reset: result=%h neg=%b co=%b expected 0 0 0",
                     result, negative, carry_out);
        end
        rst_n = 1'b1;
    endtask

    // R1: add mode with random operands.
    task automatic t_add_random();
        for (int i = 0; i < 40; i++) apply_and_check(rnd128(), rnd128(), 1'b0, "R1 add");
    endtask

    // R2: subtract with a > b.
    task automatic t_sub_pos();
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] x = rnd128();
            logic [W-1:0] y = rnd128();
            if (x > y) apply_and_check(x, y, 1'b1, "R2 sub a>b");
            else       apply_and_check(y, x, 1'b1, "R2 sub a>b");
        end
    endtask

    // R3: subtract with b > a.
    task automatic t_sub_neg();
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] x = rnd128();
            logic [W-1:0] y = rnd128();
            if (x < y) apply_and_check(x, y, 1'b1, "R3 sub b>a");
            else       apply_and_check(y, x, 1'b1, "R3 sub b>a");
        end
        apply_and_check('0, 128'd1, 1'b1, "R3 sub b>a small");
    endtask

    // R4: equal operands give zero magnitude and a clear flag.
    task automatic t_equal();
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] x = rnd128();
            apply_and_check(x, x, 1'b1, "R4 equal");
        end
        apply_and_check('0, '0, 1'b1, "R4 equal zero");
        apply_and_check('1, '1, 1'b1, "R4 equal ones");
    endtask

    // R5: the flags of the other mode stay low.
    task automatic t_mode_flags();
        apply_and_check('1, 128'd5, 1'b1, "R5 no carry in sub");
        apply_and_check(128'd3, 128'd9, 1'b0, "R5 no neg in add");
    endtask

    // R7: carries across group boundaries, including the end-around carry.
    task automatic t_boundaries();
        apply_and_check({96'd0, 32'hFFFF_FFFF}, 128'd1, 1'b0, "R7 carry g0->g1");
        apply_and_check({32'd0, {96{1'b1}}}, 128'd1, 1'b0, "R7 carry g0->g3");
        apply_and_check(128'd1 << 96, 128'd1, 1'b1, "R7 end-around ripple");
        apply_and_check(128'd1 << 32, 128'd1 << 31, 1'b1, "R7 end-around g1");
        apply_and_check(128'd1, 128'd1 << 96, 1'b1, "R7 wrap absent neg");
        for (int g = 0; g < 4; g++)
            apply_and_check(128'd1 << (32 * g), 128'd1, 1'b1, "R7 per group");
    endtask

    // R8: all-ones and all-zero corners in both modes.
    task automatic t_corners();
        apply_and_check('1, '1, 1'b0, "R8 ones+ones");
        apply_and_check('1, 128'd1, 1'b0, "R8 ones+1 overflow");
        apply_and_check('0, '0, 1'b0, "R8 zero+zero");
        apply_and_check('1, '0, 1'b1, "R8 ones-zero");
        apply_and_check('0, '1, 1'b1, "R8 zero-ones");
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_add_random();
        t_sub_pos();
        t_sub_neg();
        t_equal();
        t_mode_flags();
        t_boundaries();
        t_corners();
        t_reset();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule : test_eac_mag_adder